// File: doc/BRIEF.md
# Shared-Memory Byte Ring Accessor

This block lets a local controller exchange bytes with another processor through single-byte ring buffers that live in that processor's memory. The block reaches the remote memory only while it holds a borrowed bus. It raises a bus request, waits for the grant, issues abstract read or write requests, each completed by an acknowledge, and then drops the request. It waits for the grant to fall before it finishes the operation. How the bus is taken over and how the memory cycles are timed belong to the surroundings.

Each ring has three control bytes in remote memory at fixed offsets below its base address: a size mask, the producer index and the consumer index. Data slot `i` lives at `base + i`. Each local channel keeps a descriptor: the base, the mask, and local copies of both indices. A channel can be initialised from remote memory. It can then be asked whether it is empty or full, and it can take or deliver one byte. A get or put that cannot proceed releases the bus and polls again. A separate one-shot command resynchronises a message ring by copying its remote producer index into its remote consumer index. Only one operation runs at a time. A one-cycle `done` pulse returns the byte that was read, or a status flag.

Top module: `shm_ring_access`

## Requirements
- R1: After reset `busy`, `done`, `bus_req` and `mem_req` are low, and every channel is unconfigured (base zero).
- R2: Operation codes on `op_code` are 0 initialise, 1 is-empty, 2 is-full, 3 get, 4 put and 5 message-resync. Initialise with a nonzero `op_addr` stores it as the channel base. It then reads exactly three bytes: base−3 (mask), base−2 (producer index) and base−1 (consumer index). The three values go into the channel descriptor.
- R3: Is-empty reads the remote producer index at base−2. It reports `done_flag`=1 exactly when that value equals the local consumer index.
- R4: Is-full reads the remote consumer index at base−1. It reports `done_flag`=1 exactly when (local producer index + 1) AND mask equals that value.
- R5: Get returns the byte at base + local consumer index on `done_data`. It sets the consumer index to (index + 1) AND mask and writes the new value to base−1.
- R6: Put writes `op_wdata` to base + local producer index. It sets the producer index to (index + 1) AND mask and writes the new value to base−2.
- R7: A get on an empty ring makes no data access and no `done`. It releases the bus and polls again until the remote producer index differs from the local consumer index.
- R8: A put on a full ring makes no data access and no `done`. It releases the bus and polls again until the remote consumer index stops matching the advanced producer index.
- R9: A channel with base zero reports `done_flag`=1 for is-empty, is-full, get and put, with no bus request. Initialise with address zero unconfigures the channel.
- R10: Every memory request occurs while both `bus_req` and `bus_gnt` are high, and it holds its address until acknowledged. `bus_req` and `bus_gnt` are both low when `done` pulses.
- R11: Message-resync at `op_addr` reads base−2 and writes that byte to base−1. No channel descriptor changes.
- R12: `op_valid` is ignored while `busy` is high. Each accepted operation ends in exactly one single-cycle `done` pulse.
- R13: Channels keep separate descriptors. Operations on one channel do not change another channel's indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Start an operation (taken when idle) |
| op_code | input | 3 | Operation code (R2) |
| op_chan | input | CH_W | Channel number |
| op_addr | input | ADDR_W | Base address for initialise and message-resync |
| op_wdata | input | DATA_W | Byte for put |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_flag | output | 1 | Empty/full result, or unconfigured indication |
| done_data | output | DATA_W | Byte returned by get |
| bus_req | output | 1 | Bus borrow request |
| bus_gnt | input | 1 | Bus borrow grant |
| mem_req | output | 1 | Remote memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Remote address |
| mem_wdata | output | DATA_W | Write byte |
| mem_rdata | input | DATA_W | Read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |

## Verification
The hardest cases to reach are the waiting get and the waiting put. They need a ring that is empty or full from the block's own point of view. A remote party must then change an index while the block keeps releasing and re-borrowing the bus. The bench fills one ring with puts until the advanced producer index meets the remote consumer index, and drains the other. It starts the blocked operation and confirms that no `done` appears and that the bus is taken more than once. Only then does it change the remote index in its memory model. The same blocked get is used to show that a second `op_valid` during the wait leaves the other channel untouched.

// File: rtl/ringacc_pkg.sv
package ringacc_pkg;

   typedef enum logic [2:0] {
      OP_INIT    = 3'd0,
      OP_EMPTY   = 3'd1,
      OP_FULL    = 3'd2,
      OP_GET     = 3'd3,
      OP_PUT     = 3'd4,
      OP_MSGSYNC = 3'd5
   } ring_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACQ,
      ST_ACC,
      ST_REL,
      ST_DONE
   } seq_state_e;

endpackage

// File: rtl/ringacc_desc.sv
module ringacc_desc #(
   parameter int N_CHAN = 2,
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8,
   localparam int CH_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_W-1:0]   sel,
   input  logic              set_base,
   input  logic [ADDR_W-1:0] base_val,
   input  logic              wr_mask,
   input  logic              wr_in,
   input  logic              wr_out,
   input  logic [DATA_W-1:0] wr_val,
   output logic [ADDR_W-1:0] d_base,
   output logic [DATA_W-1:0] d_mask,
   output logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] d_out
);

   logic [ADDR_W-1:0] base_v [N_CHAN];
   logic [DATA_W-1:0] mask_v [N_CHAN];
   logic [DATA_W-1:0] in_v   [N_CHAN];
   logic [DATA_W-1:0] out_v  [N_CHAN];

   for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
      logic              hit;
      logic [ADDR_W-1:0] base_r;
      logic [DATA_W-1:0] mask_r, in_r, out_r;

      assign hit = (32'(sel) == c);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_r <= '0;
            mask_r <= '0;
            in_r   <= '0;
            out_r  <= '0;
         end else if (hit) begin
            if (set_base) begin
               base_r <= base_val;
               mask_r <= '0;
               in_r   <= '0;
               out_r  <= '0;
            end else begin
               if (wr_mask) mask_r <= wr_val;
               if (wr_in)   in_r   <= wr_val;
               if (wr_out)  out_r  <= wr_val;
            end
         end
      end

      assign base_v[c] = base_r;
      assign mask_v[c] = mask_r;
      assign in_v[c]   = in_r;
      assign out_v[c]  = out_r;
   end

   always_comb begin
      d_base = '0;
      d_mask = '0;
      d_in   = '0;
      d_out  = '0;
      for (int c = 0; c < N_CHAN; c++) begin
         if (32'(sel) == c) begin
            d_base = base_v[c];
            d_mask = mask_v[c];
            d_in   = in_v[c];
            d_out  = out_v[c];
         end
      end
   end

endmodule

// File: rtl/ringacc_seq.sv
module ringacc_seq
   import ringacc_pkg::*;
#(
   parameter int N_CHAN = 2,
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] OFS_MASK = '0,
   parameter logic [ADDR_W-1:0] OFS_IN   = '0,
   parameter logic [ADDR_W-1:0] OFS_OUT  = '0,
   localparam int CH_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [CH_W-1:0]   op_chan,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_wdata,
   input  logic [ADDR_W-1:0] d_base,
   input  logic [DATA_W-1:0] d_mask,
   input  logic [DATA_W-1:0] d_in,
   input  logic [DATA_W-1:0] d_out,
   output logic [CH_W-1:0]   sel,
   output logic              set_base,
   output logic              wr_mask,
   output logic              wr_in,
   output logic              wr_out,
   output logic [DATA_W-1:0] wr_val,
   output logic              busy,
   output logic              done,
   output logic              done_flag,
   output logic [DATA_W-1:0] done_data,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);

   seq_state_e        st;
   ring_op_e          op_q, op_in;
   logic [CH_W-1:0]   ch_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] dat_q, tmp_q;
   logic [1:0]        stp;
   logic              retry_q;

   logic [DATA_W-1:0] in_nx, out_nx;
   logic [ADDR_W-1:0] off, bsel;
   logic              last, stall, acked;
   logic              no_bus, no_bus_flag, known_op;

   assign op_in  = ring_op_e'(op_code);
   assign sel    = (st == ST_IDLE) ? op_chan : ch_q;
   assign in_nx  = (d_in + 1'b1) & d_mask;
   assign out_nx = (d_out + 1'b1) & d_mask;
   assign acked  = (st == ST_ACC) && mem_ack;

   // Decide at acceptance whether the operation touches the bus at all.
   always_comb begin
      known_op    = 1'b1;
      no_bus_flag = 1'b0;
      no_bus      = 1'b0;
      case (op_in)
         OP_INIT, OP_MSGSYNC: no_bus = (op_addr == '0);
         OP_EMPTY, OP_FULL, OP_GET, OP_PUT: begin
            no_bus      = (d_base == '0);
            no_bus_flag = no_bus;
         end
         default: begin
            known_op = 1'b0;
            no_bus   = 1'b1;
         end
      endcase
   end

   assign set_base = (st == ST_IDLE) && op_valid && known_op && (op_in == OP_INIT);

   // Access plan for each operation step.
   always_comb begin
      off       = '0;
      mem_we    = 1'b0;
      mem_wdata = '0;
      last      = 1'b0;
      stall     = 1'b0;
      bsel      = (op_q == OP_MSGSYNC) ? addr_q : d_base;
      case (op_q)
         OP_INIT: begin
            off  = (stp == 2'd0) ? OFS_MASK : (stp == 2'd1) ? OFS_IN : OFS_OUT;
            last = (stp == 2'd2);
         end
         OP_EMPTY: begin
            off  = OFS_IN;
            last = 1'b1;
         end
         OP_FULL: begin
            off  = OFS_OUT;
            last = 1'b1;
         end
         OP_GET: begin
            case (stp)
               2'd0:    begin off = OFS_IN; stall = (mem_rdata == d_out); end
               2'd1:    off = ADDR_W'(d_out);
               default: begin off = OFS_OUT; mem_we = 1'b1; mem_wdata = out_nx; last = 1'b1; end
            endcase
         end
         OP_PUT: begin
            case (stp)
               2'd0:    begin off = OFS_OUT; stall = (in_nx == mem_rdata); end
               2'd1:    begin off = ADDR_W'(d_in); mem_we = 1'b1; mem_wdata = dat_q; end
               default: begin off = OFS_IN; mem_we = 1'b1; mem_wdata = in_nx; last = 1'b1; end
            endcase
         end
         OP_MSGSYNC: begin
            if (stp == 2'd0) begin
               off = OFS_IN;
            end else begin
               off = OFS_OUT; mem_we = 1'b1; mem_wdata = tmp_q; last = 1'b1;
            end
         end
         default: ;
      endcase
   end

   assign mem_addr = bsel + off;

   // Descriptor updates, each on the acknowledge of its access.
   assign wr_mask = acked && (op_q == OP_INIT) && (stp == 2'd0);
   assign wr_in   = acked && (((op_q == OP_INIT) && (stp == 2'd1)) ||
                              ((op_q == OP_PUT)  && (stp == 2'd2)));
   assign wr_out  = acked && (((op_q == OP_INIT) && (stp == 2'd2)) ||
                              ((op_q == OP_GET)  && (stp == 2'd2)));
   assign wr_val  = (op_q == OP_INIT) ? mem_rdata :
                    (op_q == OP_PUT)  ? in_nx : out_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         op_q      <= OP_INIT;
         ch_q      <= '0;
         addr_q    <= '0;
         dat_q     <= '0;
         tmp_q     <= '0;
         stp       <= '0;
         retry_q   <= 1'b0;
         done_flag <= 1'b0;
         done_data <= '0;
      end else begin
         case (st)
            ST_IDLE: if (op_valid) begin
               op_q      <= op_in;
               ch_q      <= op_chan;
               addr_q    <= op_addr;
               dat_q     <= op_wdata;
               stp       <= '0;
               retry_q   <= 1'b0;
               done_flag <= no_bus_flag;
               done_data <= '0;
               st        <= no_bus ? ST_DONE : ST_ACQ;
            end
            ST_ACQ: if (bus_gnt) st <= ST_ACC;
            ST_ACC: if (mem_ack) begin
               if (op_q == OP_EMPTY) done_flag <= (mem_rdata == d_out);
               if (op_q == OP_FULL)  done_flag <= (in_nx == mem_rdata);
               if ((op_q == OP_GET) && (stp == 2'd1)) done_data <= mem_rdata;
               if ((op_q == OP_MSGSYNC) && (stp == 2'd0)) tmp_q <= mem_rdata;
               if (last) begin
                  st <= ST_REL;
               end else if ((stp == 2'd0) && stall) begin
                  retry_q <= 1'b1;
                  st      <= ST_REL;
               end else begin
                  stp <= stp + 2'd1;
               end
            end
            ST_REL: if (!bus_gnt) begin
               if (retry_q) begin
                  retry_q <= 1'b0;
                  stp     <= '0;
                  st      <= ST_ACQ;
               end else begin
                  st <= ST_DONE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign bus_req = (st == ST_ACQ) || (st == ST_ACC);
   assign mem_req = (st == ST_ACC);
   assign done    = (st == ST_DONE);
   assign busy    = (st != ST_IDLE);

endmodule

// File: rtl/shm_ring_access.sv
module shm_ring_access #(
   parameter int N_CHAN = 2,
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] OFS_MASK = {ADDR_W{1'b1}} - ADDR_W'(2),
   parameter logic [ADDR_W-1:0] OFS_IN   = {ADDR_W{1'b1}} - ADDR_W'(1),
   parameter logic [ADDR_W-1:0] OFS_OUT  = {ADDR_W{1'b1}},
   localparam int CH_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [CH_W-1:0]   op_chan,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_wdata,
   output logic              busy,
   output logic              done,
   output logic              done_flag,
   output logic [DATA_W-1:0] done_data,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);

   if (N_CHAN < 1) begin : g_bad_chan
      $error("N_CHAN must be at least 1");
   end
   if (DATA_W < 2 || ADDR_W <= DATA_W) begin : g_bad_width
      $error("ADDR_W must exceed DATA_W, and DATA_W must be at least 2");
   end
   if (OFS_MASK == OFS_IN || OFS_MASK == OFS_OUT || OFS_IN == OFS_OUT) begin : g_bad_ofs
      $error("control byte offsets must differ");
   end

   logic [CH_W-1:0]   sel;
   logic              set_base, wr_mask, wr_in, wr_out;
   logic [DATA_W-1:0] wr_val, d_mask, d_in, d_out;
   logic [ADDR_W-1:0] d_base;

   ringacc_desc #(
      .N_CHAN (N_CHAN),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) desc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .set_base (set_base),
      .base_val (op_addr),
      .wr_mask  (wr_mask),
      .wr_in    (wr_in),
      .wr_out   (wr_out),
      .wr_val   (wr_val),
      .d_base   (d_base),
      .d_mask   (d_mask),
      .d_in     (d_in),
      .d_out    (d_out)
   );

   ringacc_seq #(
      .N_CHAN   (N_CHAN),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .OFS_MASK (OFS_MASK),
      .OFS_IN   (OFS_IN),
      .OFS_OUT  (OFS_OUT)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .op_chan   (op_chan),
      .op_addr   (op_addr),
      .op_wdata  (op_wdata),
      .d_base    (d_base),
      .d_mask    (d_mask),
      .d_in      (d_in),
      .d_out     (d_out),
      .sel       (sel),
      .set_base  (set_base),
      .wr_mask   (wr_mask),
      .wr_in     (wr_in),
      .wr_out    (wr_out),
      .wr_val    (wr_val),
      .busy      (busy),
      .done      (done),
      .done_flag (done_flag),
      .done_data (done_data),
      .bus_req   (bus_req),
      .bus_gnt   (bus_gnt),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack)
   );

endmodule

// File: rtl/ringacc_chk.sv
module ringacc_chk #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic              busy,
   input logic              done,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr
);

   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bus_req && !mem_req && !done));

   p_access_in_tenure_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (bus_req && bus_gnt));

   p_access_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   p_done_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!bus_req && !bus_gnt));

   p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   p_start_from_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && op_valid) |=> busy);

endmodule

bind shm_ring_access ringacc_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .busy     (busy),
   .done     (done),
   .bus_req  (bus_req),
   .bus_gnt  (bus_gnt),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_ack  (mem_ack),
   .mem_addr (mem_addr)
);

// File: tb/shm_ring_access_tb_top.sv
`timescale 1ns/1ps
module shm_ring_access_tb_top;

   localparam int ADDR_W = 20;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              op_valid = 1'b0;
   logic [2:0]        op_code = '0;
   logic [0:0]        op_chan = '0;
   logic [ADDR_W-1:0] op_addr = '0;
   logic [DATA_W-1:0] op_wdata = '0;
   logic              busy, done, done_flag;
   logic [DATA_W-1:0] done_data;
   logic              bus_req, bus_gnt;
   logic              mem_req, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] mem_rdata = '0;
   logic              mem_ack = 1'b0;

   always #5 clk = ~clk;

   shm_ring_access dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_chan(op_chan), .op_addr(op_addr), .op_wdata(op_wdata),
      .busy(busy), .done(done), .done_flag(done_flag), .done_data(done_data),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack)
   );

   // Remote memory and bus grant model
   logic [7:0] mem [4096];
   logic [1:0] gsh = '0;
   int rd_cnt = 0, wr_cnt = 0, ten_cnt = 0, done_cnt = 0, cyc = 0;
   logic req_d = 1'b0;
   int checks = 0, fails = 0;

   assign bus_gnt = gsh[1];

   always @(posedge clk) begin
      gsh   <= {gsh[0], bus_req};
      req_d <= bus_req;
      if (bus_req && !req_d) ten_cnt <= ten_cnt + 1;
      if (done) done_cnt <= done_cnt + 1;
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            mem[mem_addr[11:0]] = mem_wdata;
            wr_cnt = wr_cnt + 1;
         end else begin
            mem_rdata <= mem[mem_addr[11:0]];
            rd_cnt = rd_cnt + 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic start_op(input logic [2:0] code, input logic ch,
                           input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      op_code  = code;
      op_chan  = ch;
      op_addr  = a;
      op_wdata = d;
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic wait_done(input string tag, output logic flag, output logic [7:0] data);
      int n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      if (!done) begin
         fails = fails + 1;
         $display("FAIL %s no done act=0 exp=1", tag);
      end
      flag = done_flag;
      data = done_data;
      @(negedge clk);
   endtask

   task automatic run_op(input string tag, input logic [2:0] code, input logic ch,
                         input logic [ADDR_W-1:0] a, input logic [7:0] d,
                         output logic flag, output logic [7:0] data);
      start_op(code, ch, a, d);
      wait_done(tag, flag, data);
   endtask

   // Waits n cycles and reports whether done appeared.
   task automatic idle_watch(input int n, output bit saw);
      saw = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (done) saw = 1;
      end
   endtask

   logic       f;
   logic [7:0] d;

   task automatic t_reset;
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 bus_req", bus_req, 0);
      chk("R1 mem_req", mem_req, 0);
   endtask

   task automatic t_unconfigured;
      int r0 = rd_cnt, t0 = ten_cnt;
      run_op("R9 empty", 3'd1, 1'b0, '0, 8'h0, f, d); chk("R9 empty flag", f, 1);
      run_op("R9 full",  3'd2, 1'b0, '0, 8'h0, f, d); chk("R9 full flag", f, 1);
      run_op("R9 get",   3'd3, 1'b1, '0, 8'h0, f, d); chk("R9 get flag", f, 1);
      run_op("R9 put",   3'd4, 1'b1, '0, 8'h5, f, d); chk("R9 put flag", f, 1);
      chk("R9 no access", rd_cnt - r0, 0);
      chk("R9 no tenure", ten_cnt - t0, 0);
   endtask

   task automatic t_init_status;
      int r0;
      mem[12'h0FD] = 8'h07; mem[12'h0FE] = 8'h02; mem[12'h0FF] = 8'h02;
      r0 = rd_cnt;
      run_op("R2 init", 3'd0, 1'b0, 20'h00100, 8'h0, f, d);
      chk("R2 three reads", rd_cnt - r0, 3);
      run_op("R3 empty", 3'd1, 1'b0, '0, 8'h0, f, d); chk("R3 empty when equal", f, 1);
      run_op("R4 full",  3'd2, 1'b0, '0, 8'h0, f, d); chk("R4 not full", f, 0);
   endtask

   task automatic t_put_get;
      int t0 = ten_cnt;
      run_op("R6 put", 3'd4, 1'b0, '0, 8'hA5, f, d);
      chk("R6 data slot", mem[12'h102], 8'hA5);
      chk("R6 in index", mem[12'h0FE], 8'h03);
      chk("R10 one tenure", ten_cnt - t0, 1);
      run_op("R3 empty2", 3'd1, 1'b0, '0, 8'h0, f, d); chk("R3 not empty", f, 0);
      run_op("R5 get", 3'd3, 1'b0, '0, 8'h0, f, d);
      chk("R5 byte", d, 8'hA5);
      chk("R5 out index", mem[12'h0FF], 8'h03);
   endtask

   task automatic t_put_wrap_full;
      for (int i = 0; i < 7; i++) begin
         run_op("R6 fill", 3'd4, 1'b0, '0, 8'(8'h10 + i), f, d);
         if (i == 4) chk("R6 wrap to zero", mem[12'h0FE], 8'h00);
      end
      chk("R6 slot 7", mem[12'h107], 8'h14);
      chk("R6 slot 1", mem[12'h101], 8'h16);
      run_op("R4 full2", 3'd2, 1'b0, '0, 8'h0, f, d); chk("R4 full flag", f, 1);
   endtask

   task automatic t_put_waits;
      bit saw;
      int t0 = ten_cnt;
      start_op(3'd4, 1'b0, '0, 8'h77);
      idle_watch(60, saw);
      chk("R8 no done while full", saw, 0);
      chk("R8 data slot untouched", mem[12'h102], 8'hA5);
      chk("R8 polled with release", (ten_cnt - t0) > 1, 1);
      mem[12'h0FF] = 8'h04;
      wait_done("R8 put", f, d);
      chk("R8 data written", mem[12'h102], 8'h77);
      chk("R8 in index", mem[12'h0FE], 8'h03);
   endtask

   task automatic t_get_waits;
      bit saw;
      mem[12'h1FD] = 8'h03; mem[12'h1FE] = 8'h01; mem[12'h1FF] = 8'h01;
      run_op("R2 init ch1", 3'd0, 1'b1, 20'h00200, 8'h0, f, d);
      start_op(3'd3, 1'b1, '0, 8'h0);
      idle_watch(60, saw);
      chk("R7 no done while empty", saw, 0);
      mem[12'h201] = 8'h5C; mem[12'h1FE] = 8'h02;
      wait_done("R7 get", f, d);
      chk("R7 byte", d, 8'h5C);
      chk("R7 out index", mem[12'h1FF], 8'h02);
      mem[12'h202] = 8'h6D; mem[12'h203] = 8'h7E; mem[12'h1FE] = 8'h00;
      run_op("R5 get a", 3'd3, 1'b1, '0, 8'h0, f, d); chk("R5 byte a", d, 8'h6D);
      run_op("R5 get b", 3'd3, 1'b1, '0, 8'h0, f, d); chk("R5 byte b", d, 8'h7E);
      chk("R5 out wrap", mem[12'h1FF], 8'h00);
      run_op("R13 ch0 empty", 3'd1, 1'b0, '0, 8'h0, f, d); chk("R13 ch0 kept", f, 1);
   endtask

   task automatic t_msgsync;
      int r0 = rd_cnt, w0 = wr_cnt;
      mem[12'h2FE] = 8'h42; mem[12'h2FF] = 8'h10;
      run_op("R11 sync", 3'd5, 1'b0, 20'h00300, 8'h0, f, d);
      chk("R11 copied", mem[12'h2FF], 8'h42);
      chk("R11 one read", rd_cnt - r0, 1);
      chk("R11 one write", wr_cnt - w0, 1);
      run_op("R11 ch1 empty", 3'd1, 1'b1, '0, 8'h0, f, d); chk("R11 ch1 kept", f, 1);
   endtask

   task automatic t_busy_ignore;
      bit saw;
      int c0;
      logic [7:0] slot3;
      slot3 = mem[12'h103];
      start_op(3'd3, 1'b1, '0, 8'h0);
      idle_watch(10, saw);
      c0 = done_cnt;
      start_op(3'd4, 1'b0, '0, 8'h99);
      mem[12'h200] = 8'h11; mem[12'h1FE] = 8'h01;
      wait_done("R12 get", f, d);
      chk("R12 byte", d, 8'h11);
      idle_watch(20, saw);
      chk("R12 single done", done_cnt - c0, 1);
      chk("R12 put ignored slot", mem[12'h103], slot3);
      chk("R12 put ignored index", mem[12'h0FE], 8'h03);
   endtask

   task automatic t_deconfigure;
      int t0 = ten_cnt;
      run_op("R9 deconf", 3'd0, 1'b1, 20'h0, 8'h0, f, d);
      run_op("R9 deconf empty", 3'd1, 1'b1, '0, 8'h0, f, d);
      chk("R9 deconf flag", f, 1);
      chk("R9 deconf no bus", ten_cnt - t0, 0);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_unconfigured();
      t_init_status();
      t_put_get();
      t_put_wrap_full();
      t_put_waits();
      t_get_waits();
      t_msgsync();
      t_busy_ignore();
      t_deconfigure();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule